// File: doc/BRIEF.md
# Synchronous FIFO with Overflow/Underflow Event Monitor

This block is a single-clock first-in-first-out queue. It uses a ready/valid handshake on its producer side and on its consumer side. The storage depth is a power of two, so the read and write pointers wrap by dropping their carry bit. Apart from data flow, the block watches its own handshake for misuse. A producer that keeps offering a word while the queue refuses it counts as an overflow attempt. A consumer that asks for a word while none is held counts as an underflow attempt. Each kind of attempt is tallied in its own saturating counter.

A programmable threshold is compared against the overflow tally. When the tally reaches that threshold, a sticky request output tells the surrounding system to fall back to a slower producer mode. Firmware reads both tallies and the request flag through a small address/data register port. A single write-one-to-clear bit zeroes the tallies and withdraws the request.

Top module: `fifo_event_monitor`

## Requirements
- R1: After reset, out_valid is 0, in_ready is 1, slow_req is 0, and both tallies read 0.
- R2: Words leave in the order they were accepted. out_valid is 1 exactly when at least one word is held. While out_valid is high and out_ready is low, out_data stays stable.
- R3: in_ready is 0 only when all DEPTH entries are occupied and out_ready is 0. The queue holds exactly DEPTH words.
- R4: When the queue is full and in_valid and out_ready are both high, one word leaves and one word enters in the same cycle. This exchange is not counted as an overflow.
- R5: Each cycle with in_valid high and in_ready low adds one to the overflow tally. The tally reads at reg_addr 0 from the edge that closes that cycle.
- R6: Each cycle with out_ready high and out_valid low adds one to the underflow tally. The tally reads at reg_addr 1.
- R7: Both tallies saturate at 255 and never wrap.
- R8: slow_req rises at the same edge at which the overflow tally becomes equal to or greater than a nonzero cfg_threshold. It then stays high until cleared. A cfg_threshold of 0 never raises it. Its value reads as bit 0 at reg_addr 2, and the upper bits read 0.
- R9: A cycle with reg_wr high, reg_addr 2 and reg_wdata bit 0 set clears both tallies and slow_req at the next edge. The clear wins over any event in the same cycle.
- R10: reg_addr 3 reads 0. A write to any other address, or a write to address 2 with bit 0 clear, leaves the tallies and slow_req unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Producer offers in_data |
| in_data | input | DATA_W | Word offered by producer |
| in_ready | output | 1 | Queue accepts the offered word this cycle |
| out_valid | output | 1 | A word is available on out_data |
| out_data | output | DATA_W | Oldest held word |
| out_ready | input | 1 | Consumer takes the word this cycle |
| cfg_threshold | input | CNT_W | Overflow tally level that raises slow_req; 0 disables |
| reg_addr | input | 2 | Register select: 0 overflow tally, 1 underflow tally, 2 control/status, 3 reserved |
| reg_wr | input | 1 | Register write strobe |
| reg_wdata | input | CNT_W | Register write data; bit 0 at address 2 is the clear bit |
| reg_rdata | output | CNT_W | Read data for reg_addr |
| slow_req | output | 1 | Sticky request to throttle the producer |

## Verification
Two pairs of functions can land in the same cycle. A clear can coincide with a counted overflow. A full-queue exchange can coincide with an offered write that would otherwise count as an overflow. The bench fills the queue, holds the producer against it, and pulses the clear in the same cycle. It also sweeps every in_valid/out_ready pairing at every fill level from empty to full. After each edge it reads all registers back and compares them with tallies kept arithmetically in the bench. A clear that loses to an event, or an exchange that gets counted, shows up as a tally mismatch at that edge.

// File: rtl/fem_pkg.sv
package fem_pkg;
    typedef enum logic [1:0] {
        REG_OVF  = 2'd0,
        REG_UNF  = 2'd1,
        REG_CTRL = 2'd2,
        REG_RSVD = 2'd3
    } fem_reg_e;

    localparam int CLR_BIT  = 0;
    localparam int NUM_EVT  = 2;
    localparam int EVT_OVF  = 0;
    localparam int EVT_UNF  = 1;
endpackage

// File: rtl/fem_storage.sv
module fem_storage #(
    parameter int DATA_W = 8,
    parameter int DEPTH  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [DATA_W-1:0] wr_data,
    output logic [DATA_W-1:0] rd_data,
    output logic              full,
    output logic              empty
);
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int LVL_W = PTR_W + 1;

    generate
        if ((1 << PTR_W) != DEPTH) begin : g_depth_check
            $error("DEPTH must be a power of two");
        end
    endgenerate

    typedef struct packed {
        logic [PTR_W-1:0] wr_ptr;
        logic [PTR_W-1:0] rd_ptr;
        logic [LVL_W-1:0] level;
    } stor_state_t;

    stor_state_t s_d, s_q;
    logic [DATA_W-1:0] mem_q [DEPTH];

    always_comb begin
        s_d = s_q;
        // pointers wrap by their natural width (mask, no modulo)
        if (wr_en) s_d.wr_ptr = s_q.wr_ptr + 1'b1;
        if (rd_en) s_d.rd_ptr = s_q.rd_ptr + 1'b1;
        unique case ({wr_en, rd_en})
            2'b10:   s_d.level = s_q.level + 1'b1;
            2'b01:   s_d.level = s_q.level - 1'b1;
            default: s_d.level = s_q.level;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    always_ff @(posedge clk) begin
        if (wr_en) mem_q[s_q.wr_ptr] <= wr_data;
    end

    assign rd_data = mem_q[s_q.rd_ptr];
    assign full    = (s_q.level == LVL_W'(DEPTH));
    assign empty   = (s_q.level == '0);
endmodule

// File: rtl/fem_sat_ctr.sv
module fem_sat_ctr #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             inc,
    input  logic             clr,
    output logic [CNT_W-1:0] value,
    output logic [CNT_W-1:0] value_next
);
    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
    } ctr_state_t;

    ctr_state_t c_d, c_q;

    always_comb begin
        c_d = c_q;
        if (clr)                         c_d.cnt = '0;
        else if (inc && c_q.cnt != CNT_MAX) c_d.cnt = c_q.cnt + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) c_q <= '0;
        else        c_q <= c_d;
    end

    assign value      = c_q.cnt;
    assign value_next = c_d.cnt;
endmodule

// File: rtl/fem_regif.sv
module fem_regif
    import fem_pkg::*;
#(
    parameter int CNT_W = 8
) (
    input  logic [1:0]       reg_addr,
    input  logic             reg_wr,
    input  logic [CNT_W-1:0] reg_wdata,
    input  logic [CNT_W-1:0] ovf_cnt,
    input  logic [CNT_W-1:0] unf_cnt,
    input  logic             slow,
    output logic [CNT_W-1:0] reg_rdata,
    output logic             clr
);
    fem_reg_e sel;

    always_comb begin
        sel = fem_reg_e'(reg_addr);
        unique case (sel)
            REG_OVF:  reg_rdata = ovf_cnt;
            REG_UNF:  reg_rdata = unf_cnt;
            REG_CTRL: reg_rdata = {{(CNT_W-1){1'b0}}, slow};
            default:  reg_rdata = '0;
        endcase
        clr = reg_wr && (sel == REG_CTRL) && reg_wdata[CLR_BIT];
    end
endmodule

// File: rtl/fifo_event_monitor.sv
module fifo_event_monitor
    import fem_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int DEPTH  = 4,
    parameter int CNT_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [DATA_W-1:0] in_data,
    output logic              in_ready,
    output logic              out_valid,
    output logic [DATA_W-1:0] out_data,
    input  logic              out_ready,
    input  logic [CNT_W-1:0]  cfg_threshold,
    input  logic [1:0]        reg_addr,
    input  logic              reg_wr,
    input  logic [CNT_W-1:0]  reg_wdata,
    output logic [CNT_W-1:0]  reg_rdata,
    output logic              slow_req
);
    typedef struct packed {
        logic slow;
    } mon_state_t;

    mon_state_t m_d, m_q;

    logic full, empty, wr_en, rd_en, clr;
    logic [NUM_EVT-1:0]  evt;
    logic [CNT_W-1:0]    cnt      [NUM_EVT];
    logic [CNT_W-1:0]    cnt_next [NUM_EVT];
    logic [CNT_W-1:0]    ovf_cnt, unf_cnt;

    fem_storage #(.DATA_W(DATA_W), .DEPTH(DEPTH)) i_storage (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .rd_en   (rd_en),
        .wr_data (in_data),
        .rd_data (out_data),
        .full    (full),
        .empty   (empty)
    );

    // full queue still accepts when the head leaves in the same cycle
    assign in_ready  = !full || out_ready;
    assign out_valid = !empty;
    assign wr_en     = in_valid && in_ready;
    assign rd_en     = out_ready && !empty;

    assign evt[EVT_OVF] = in_valid && !in_ready;
    assign evt[EVT_UNF] = out_ready && empty;

    generate
        for (genvar g = 0; g < NUM_EVT; g++) begin : g_evt_ctr
            fem_sat_ctr #(.CNT_W(CNT_W)) i_ctr (
                .clk        (clk),
                .rst_n      (rst_n),
                .inc        (evt[g]),
                .clr        (clr),
                .value      (cnt[g]),
                .value_next (cnt_next[g])
            );
        end
    endgenerate

    assign ovf_cnt = cnt[EVT_OVF];
    assign unf_cnt = cnt[EVT_UNF];

    fem_regif #(.CNT_W(CNT_W)) i_regif (
        .reg_addr  (reg_addr),
        .reg_wr    (reg_wr),
        .reg_wdata (reg_wdata),
        .ovf_cnt   (ovf_cnt),
        .unf_cnt   (unf_cnt),
        .slow      (m_q.slow),
        .reg_rdata (reg_rdata),
        .clr       (clr)
    );

    always_comb begin
        m_d = m_q;
        if (clr)
            m_d.slow = 1'b0;
        else if (cfg_threshold != '0 && cnt_next[EVT_OVF] >= cfg_threshold)
            m_d.slow = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) m_q <= '0;
        else        m_q <= m_d;
    end

    assign slow_req = m_q.slow;
endmodule

// File: rtl/fem_checker.sv
module fem_checker #(
    parameter int DATA_W = 8,
    parameter int CNT_W  = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              in_valid,
    input logic              in_ready,
    input logic              out_valid,
    input logic              out_ready,
    input logic [DATA_W-1:0] out_data,
    input logic [1:0]        reg_addr,
    input logic              reg_wr,
    input logic [CNT_W-1:0]  reg_wdata,
    input logic [CNT_W-1:0]  ovf_cnt,
    input logic [CNT_W-1:0]  unf_cnt,
    input logic              slow_req
);
    localparam logic [CNT_W-1:0] CMAX = '1;
    logic clr_req;
    assign clr_req = reg_wr && reg_addr == 2'd2 && reg_wdata[0];

    AST_HOLD_HEAD: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && !out_ready |=> out_valid && $stable(out_data)); // R2
    AST_READY_WHEN_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
        !out_valid |-> in_ready); // R3
    AST_OVF_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid && !in_ready && !clr_req && ovf_cnt != CMAX |=> ovf_cnt == $past(ovf_cnt) + 1'b1); // R5
    AST_UNF_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        out_ready && !out_valid && !clr_req && unf_cnt != CMAX |=> unf_cnt == $past(unf_cnt) + 1'b1); // R6
    AST_OVF_SATURATE: assert property (@(posedge clk) disable iff (!rst_n)
        ovf_cnt == CMAX && !clr_req |=> ovf_cnt == CMAX); // R7
    AST_SLOW_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        slow_req && !clr_req |=> slow_req); // R8
    AST_CLEAR_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        clr_req |=> ovf_cnt == '0 && unf_cnt == '0 && !slow_req); // R9
endmodule

bind fifo_event_monitor fem_checker #(.DATA_W(DATA_W), .CNT_W(CNT_W)) i_fem_checker (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_ready  (in_ready),
    .out_valid (out_valid),
    .out_ready (out_ready),
    .out_data  (out_data),
    .reg_addr  (reg_addr),
    .reg_wr    (reg_wr),
    .reg_wdata (reg_wdata),
    .ovf_cnt   (ovf_cnt),
    .unf_cnt   (unf_cnt),
    .slow_req  (slow_req)
);

// File: tb/test_fifo_event_monitor.sv
module test_fifo_event_monitor;
    localparam int CLK_PERIOD = 20;
    localparam int DW = 8;
    localparam int D  = 4;
    localparam int CW = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic in_valid = 1'b0, in_ready, out_valid, out_ready = 1'b0;
    logic [DW-1:0] in_data = '0, out_data;
    logic [CW-1:0] cfg_threshold = '0, reg_wdata = '0, reg_rdata;
    logic [1:0] reg_addr = '0;
    logic reg_wr = 1'b0, slow_req;

    int nchk = 0, nerr = 0;
    bit done = 0;
    int mq[$];
    int m_ovf = 0, m_unf = 0;
    bit m_slow = 0;
    int dctr = 1;
    logic [15:0] lfsr = 16'hACE1;

    always #(CLK_PERIOD/2) clk = ~clk;

    fifo_event_monitor #(.DATA_W(DW), .DEPTH(D), .CNT_W(CW)) i_fifo_event_monitor (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
        .in_ready(in_ready), .out_valid(out_valid), .out_data(out_data),
        .out_ready(out_ready), .cfg_threshold(cfg_threshold), .reg_addr(reg_addr),
        .reg_wr(reg_wr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .slow_req(slow_req)
    );

    task automatic chk(input string tag, input int act, input int exp);
        nchk++;
        if (act != exp) begin
            nerr++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic read_regs();
        reg_wr = 1'b0;
        reg_addr = 2'd0; #1; chk("R5 ovf tally", reg_rdata, m_ovf);
        reg_addr = 2'd1; #1; chk("R6 unf tally", reg_rdata, m_unf);
        reg_addr = 2'd2; #1; chk("R8 status reg", reg_rdata, int'(m_slow));
        reg_addr = 2'd3; #1; chk("R10 reserved reg", reg_rdata, 0);
        chk("R8 slow_req", slow_req, int'(m_slow));
    endtask

    task automatic step(input bit iv, input bit ordy, input bit rwr,
                        input int raddr, input int rwd);
        bit e_rdy, e_val, clr;
        @(negedge clk);
        in_valid = iv; out_ready = ordy; in_data = DW'(dctr);
        reg_wr = rwr; reg_addr = 2'(raddr); reg_wdata = CW'(rwd);
        #1;
        e_val = (mq.size() > 0);
        e_rdy = (mq.size() < D) || ordy;
        chk("R2 out_valid", out_valid, int'(e_val));
        chk("R3 in_ready", in_ready, int'(e_rdy));
        if (e_val) chk("R2 out_data order", out_data, mq[0]);
        clr = rwr && raddr == 2 && rwd[0];
        if (ordy && e_val) void'(mq.pop_front());
        if (iv && e_rdy) begin mq.push_back(dctr & 8'hFF); dctr++; end
        if (clr) begin m_ovf = 0; m_unf = 0; m_slow = 0; end
        else begin
            if (iv && !e_rdy && m_ovf < 255) m_ovf++;
            if (ordy && !e_val && m_unf < 255) m_unf++;
            if (cfg_threshold != 0 && m_ovf >= int'(cfg_threshold)) m_slow = 1;
        end
        @(posedge clk); #1;
        read_regs();
    endtask

    task automatic drain();
        while (mq.size() > 0) step(0, 1, 0, 0, 0);
    endtask

    task automatic do_clear();
        step(0, 0, 1, 2, 1);
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        if (!done) begin
            nerr++; nchk++;
            $display("FAIL watchdog expired");
            $display("Result: errors=%0d of %0d checks", nerr, nchk);
            $finish;
        end
    end

    initial begin
        #(CLK_PERIOD*3 + 3);
        rst_n = 1'b1;
        #2;
        // R1 reset state
        chk("R1 out_valid", out_valid, 0);
        chk("R1 in_ready", in_ready, 1);
        chk("R1 slow_req", slow_req, 0);
        reg_addr = 2'd0; #1; chk("R1 ovf tally", reg_rdata, 0);
        reg_addr = 2'd1; #1; chk("R1 unf tally", reg_rdata, 0);

        // fill against a stalled consumer; threshold 3
        cfg_threshold = 8'd3;
        for (int i = 0; i < 8; i++) step(1, 0, 0, 0, 0);
        chk("R3 full depth", mq.size(), D);
        chk("R8 slow after 4 ovf", slow_req, 1);
        drain();
        for (int i = 0; i < 2; i++) step(0, 1, 0, 0, 0);

        // R4 exchange at full
        do_clear();
        for (int i = 0; i < D; i++) step(1, 0, 0, 0, 0);
        for (int i = 0; i < 5; i++) step(1, 1, 0, 0, 0);
        reg_addr = 2'd0; #1; chk("R4 exchange not counted", reg_rdata, 0);

        // R9 clear in the same cycle as an overflow
        step(1, 0, 0, 0, 0);
        step(1, 0, 1, 2, 1);
        reg_addr = 2'd0; #1; chk("R9 clear beats ovf", reg_rdata, 0);
        step(1, 0, 0, 0, 0);
        step(1, 0, 0, 0, 0);
        // R10 writes that must not clear
        step(0, 0, 1, 0, 1);
        step(0, 0, 1, 1, 1);
        step(0, 0, 1, 2, 2);
        step(0, 0, 1, 3, 1);
        reg_addr = 2'd0; #1; chk("R10 ignored writes", reg_rdata, 2);
        chk("R10 slow kept", slow_req, 0);

        // R7 saturation, with threshold 0 disabling slow_req (R8)
        cfg_threshold = 8'd0;
        do_clear();
        for (int i = 0; i < 300; i++) step(1, 0, 0, 0, 0);
        reg_addr = 2'd0; #1; chk("R7 ovf saturated", reg_rdata, 255);
        chk("R8 threshold 0 disabled", slow_req, 0);
        drain();
        for (int i = 0; i < 300; i++) step(0, 1, 0, 0, 0);
        reg_addr = 2'd1; #1; chk("R7 unf saturated", reg_rdata, 255);

        // sweep every handshake pairing at every fill level
        for (int t = 1; t <= 3; t++) begin
            cfg_threshold = CW'(t * 2 - 1);
            for (int lvl = 0; lvl <= D; lvl++) begin
                for (int c = 0; c < 4; c++) begin
                    drain();
                    do_clear();
                    for (int k = 0; k < lvl; k++) step(1, 0, 0, 0, 0);
                    step(c[0], c[1], 0, 0, 0);
                    step(c[0], c[1], c == 3 && lvl == D, 2, 1);
                end
            end
        end

        // pseudo-random traffic with sparse clears
        for (int i = 0; i < 2000; i++) begin
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            if (i % 500 == 0) cfg_threshold = CW'(lfsr[3:0]);
            step(lfsr[0], lfsr[1] & lfsr[2], lfsr[7:3] == 5'd0, 2, 1);
        end

        done = 1;
        $display("Result: errors=%0d of %0d checks", nerr, nchk);
        $finish;
    end
endmodule